// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block turns a serial bit stream into a parallel word. A chain of flops moves one position on each rising edge of a shift clock and takes a new bit from the serial input. A separate holding register copies the whole chain on each rising edge of its own storage clock. The parallel outputs therefore change only when the user decides to publish, however many bits have been shifted since the last publish. The last stage of the chain is always driven on a cascade pin, so several blocks can be chained into a wider word.

An active-low clear empties the shift chain at once and overrides the shift clock. It does not touch the holding register. An active-low output enable lets the parallel outputs drive the held word or float them to high impedance. A separate enable flag carries the same state for use in synthesis. The stream has no valid/ready pair: each shift-clock edge is one accepted bit, and the block never applies back-pressure. The sender owns the pace of both clocks.

Top module: `serial_latch_out`

## Requirements
- R1: While `shclr_n_i` is low, every shift stage is 0, so `cascade_o` reads 0.
- R2: On a rising edge of `shclk_i` with clear high, stage 0 takes `sdata_i` and stage k takes stage k-1. Stage k appears on `pout_o[k]` after a store. The first of eight bits shifted ends on bit 7.
- R3: A low `shclr_n_i` overrides `shclk_i`: a shift edge during clear leaves the chain at zero.
- R4: On a rising edge of `stclk_i`, the holding register takes the shift chain's contents. Between such edges `pout_o` does not follow the chain.
- R5: With `oe_n_i` high, `pout_en_o` is 0 and `pout_o` is high impedance. With it low, `pout_en_o` is 1 and `pout_o` carries the held word.
- R6: `cascade_o` always carries the last shift stage, whatever the state of `oe_n_i`.
- R7: When both clocks rise together, the holding register takes the chain's value from before that edge, so it lags the chain by one bit.
- R8: Clearing the shift chain leaves the held word and `pout_o` unchanged until the next storage edge.
- R9: The holding register starts at zero.
- R10: Two blocks chained through `cascade_o` into `sdata_i`, sharing their clocks, hold 16 shifted bits. The first bit sent is on bit 7 of the far block after one store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sdata_i | input | 1 | Serial data bit, taken on the shift clock edge |
| shclk_i | input | 1 | Shift clock, rising edge |
| shclr_n_i | input | 1 | Asynchronous clear of the shift chain, active low |
| stclk_i | input | 1 | Storage clock, rising edge |
| oe_n_i | input | 1 | Parallel output enable, active low |
| pout_o | output | W (8) | Held word, or high impedance when disabled |
| pout_en_o | output | 1 | High when `pout_o` is being driven |
| cascade_o | output | 1 | Last shift stage, always driven |

## Verification
A shifted bit reaches `cascade_o` in the same shift edge, with no further register, so the bench reads it one nanosecond after that edge. A shifted bit reaches `pout_o` only after the next storage edge. The driver therefore queues the expected word before it raises `stclk_i`, and the monitor compares one nanosecond after the falling storage edge. The enable and clear act without any clock and are sampled one nanosecond after they change. The shared-edge case queues the pre-edge model value, not the post-edge one.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_W_DEFAULT = 8;

  function automatic logic [SIPO_W_DEFAULT-1:0] sipo_step(
    input logic [SIPO_W_DEFAULT-1:0] cur, input logic bit_in);
    return {cur[SIPO_W_DEFAULT-2:0], bit_in};
  endfunction
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         clr_n_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  // stage 0 takes the serial bit, each later stage its predecessor
  for (genvar g = 0; g < W; g++) begin : g_link
    if (g == 0) begin : g_head
      assign nxt[g] = bit_i;
    end else begin : g_body
      assign nxt[g] = q_o[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) q_o <= '0;
    else          q_o <= nxt;
  end
endmodule

// File: rtl/sipo_hold_stage.sv
module sipo_hold_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // no reset by design; power-on value fixed to zero
  logic [W-1:0] held = '0;

  always_ff @(posedge clk_i) held <= d_i;

  assign q_o = held;
endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
  parameter int unsigned W = 8
) (
  input  logic         oe_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] pad_o,
  output logic         en_o
);
  assign en_o = ~oe_n_i;

  for (genvar g = 0; g < W; g++) begin : g_pad
    assign pad_o[g] = en_o ? d_i[g] : 1'bz;
  end
endmodule

// File: rtl/serial_latch_out.sv
module serial_latch_out
  import sipo_pkg::*;
#(
  parameter int unsigned W = SIPO_W_DEFAULT
) (
  input  logic         sdata_i,
  input  logic         shclk_i,
  input  logic         shclr_n_i,
  input  logic         stclk_i,
  input  logic         oe_n_i,
  output logic [W-1:0] pout_o,
  output logic         pout_en_o,
  output logic         cascade_o
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] shift_q;
  logic [W-1:0] hold_q;

  sipo_shift_stage #(.W(W)) u_shift (
    .clk_i  (shclk_i),
    .clr_n_i(shclr_n_i),
    .bit_i  (sdata_i),
    .q_o    (shift_q)
  );

  sipo_hold_stage #(.W(W)) u_hold (
    .clk_i(stclk_i),
    .d_i  (shift_q),
    .q_o  (hold_q)
  );

  sipo_out_drv #(.W(W)) u_drv (
    .oe_n_i(oe_n_i),
    .d_i   (hold_q),
    .pad_o (pout_o),
    .en_o  (pout_en_o)
  );

  assign cascade_o = shift_q[LAST];
endmodule

// File: rtl/sipo_checker.sv
module sipo_checker #(
  parameter int unsigned W = 8
) (
  input logic         shclk,
  input logic         stclk,
  input logic         clr_n,
  input logic         oe_n,
  input logic         sdata,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] pout,
  input logic         pout_en,
  input logic         cascade
);
  // marks a clear that happened since the last shift edge
  logic clr_seen = 1'b1;
  always_ff @(posedge shclk or negedge clr_n) begin
    if (!clr_n) clr_seen <= 1'b1;
    else        clr_seen <= 1'b0;
  end

  // R2: chain moves by one with the serial bit entering stage 0
  a_r2_shift: assert property (@(posedge shclk) disable iff (!clr_n)
    !clr_seen |-> shift_q == {$past(shift_q[W-2:0]), $past(sdata)});

  // R1, R3: clear holds the chain at zero even across shift edges
  a_r3_clear: assert property (@(posedge shclk)
    !clr_n |-> (shift_q == '0 && cascade == 1'b0));

  // R4: storage edge captures the chain value
  a_r4_store: assert property (@(posedge stclk) disable iff (!clr_n)
    1'b1 |=> hold_q == $past(shift_q));

  // R5: enabled outputs carry the held word
  a_r5_drive: assert property (@(posedge stclk) disable iff (!clr_n)
    !oe_n |-> (pout_en && pout == hold_q));

  // R6: cascade pin follows the last stage
  a_r6_cascade: assert property (@(posedge shclk) disable iff (!clr_n)
    !clr_seen |-> cascade == $past(shift_q[W-2]));
endmodule

bind serial_latch_out sipo_checker #(.W(W)) u_chk (
  .shclk  (shclk_i),
  .stclk  (stclk_i),
  .clr_n  (shclr_n_i),
  .oe_n   (oe_n_i),
  .sdata  (sdata_i),
  .shift_q(shift_q),
  .hold_q (hold_q),
  .pout   (pout_o),
  .pout_en(pout_en_o),
  .cascade(cascade_o)
);

// File: tb/test_serial_latch_out.sv
`timescale 1ns/1ps
module test_serial_latch_out;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic sdata = 1'b0, shclk = 1'b0, stclk = 1'b0, clr_n = 1'b0, oe_n = 1'b1;
  logic [7:0] pout_a, pout_b;
  logic en_a, en_b, casc_a, casc_b;

  serial_latch_out i_serial_latch_out (
    .sdata_i(sdata), .shclk_i(shclk), .shclr_n_i(clr_n), .stclk_i(stclk),
    .oe_n_i(oe_n), .pout_o(pout_a), .pout_en_o(en_a), .cascade_o(casc_a));

  serial_latch_out i_serial_latch_out_b (
    .sdata_i(casc_a), .shclk_i(shclk), .shclr_n_i(clr_n), .stclk_i(stclk),
    .oe_n_i(oe_n), .pout_o(pout_b), .pout_en_o(en_b), .cascade_o(casc_b));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m = '0;        // model: [7:0] near block, [15:8] far block
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    sdata = b;
    #1 shclk = 1'b1;
    m = {m[14:0], b};
    #2 shclk = 1'b0;
    #1;
  endtask

  task automatic store(string tag);
    exp_q.push_back(m);
    tag_q.push_back(tag);
    #1 stclk = 1'b1;
    #2 stclk = 1'b0;
    #2;
  endtask

  // both clocks from one edge: the store sees the pre-edge chain
  task automatic both_edge(logic b, string tag);
    sdata = b;
    exp_q.push_back(m);
    tag_q.push_back(tag);
    #1 begin shclk = 1'b1; stclk = 1'b1; end
    m = {m[14:0], b};
    #2 begin shclk = 1'b0; stclk = 1'b0; end
    #2;
  endtask

  task automatic send_word(logic [15:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      shift_bit(w[i]);
      chk("R6 cascade", {15'd0, casc_a}, {15'd0, m[7]});
    end
  endtask

  // monitor: compare the queued word after each storage pulse
  always @(negedge stclk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {pout_b, pout_a}, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #10;
    chk("R1 clear cascade", {15'd0, casc_a}, 16'd0);
    chk("R5 disabled flag", {15'd0, en_a}, 16'd0);
    oe_n = 1'b0;
    #1;
    chk("R5 enabled flag", {15'd0, en_a}, 16'd1);
    chk("R9 initial hold", {pout_b, pout_a}, 16'd0);
    clr_n = 1'b1;
    #2;

    // R2, R4: one byte through the near block
    send_word(16'h00B2, 8);
    chk("R4 no store yet", {8'd0, pout_a}, 16'd0);
    store("R2 R4 byte");

    // R5, R6: disable outputs, cascade still driven
    oe_n = 1'b1;
    #1;
    chk("R5 disabled flag", {15'd0, en_a}, 16'd0);
    chk("R6 cascade while off", {15'd0, casc_a}, {15'd0, m[7]});
    oe_n = 1'b0;
    #1;
    chk("R5 re-enabled", {8'd0, pout_a}, 16'h00B2);

    // R1, R3, R8: clear the chain, hold stays
    clr_n = 1'b0;
    m = '0;
    #1;
    chk("R1 cleared cascade", {15'd0, casc_a}, 16'd0);
    chk("R8 hold kept", {8'd0, pout_a}, 16'h00B2);
    sdata = 1'b1;
    #1 shclk = 1'b1;
    #2 shclk = 1'b0;
    #1;
    chk("R3 shift overridden", {15'd0, casc_a}, 16'd0);
    clr_n = 1'b1;
    #2;
    store("R3 R8 zero after clear");

    // R10: two chained blocks hold 16 bits
    send_word(16'hC3A5, 16);
    chk("R10 far cascade", {15'd0, casc_b}, 16'd1);
    store("R10 sixteen bits");

    // R7: shared clock edges
    both_edge(1'b0, "R7 lag 1");
    both_edge(1'b1, "R7 lag 2");
    both_edge(1'b1, "R7 lag 3");
    store("R7 catch up");

    // R2: alternating pattern
    send_word(16'h5A0F, 16);
    store("R2 alternating");
    #5;
    chk("R4 queue drained", 16'(exp_q.size()), 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule